// File: doc/BRIEF.md
# CPU Run-Control and Breakpoint Unit

This unit decides, clock by clock, whether a small multi-cycle accumulator processor may advance. It takes pulses from debounced push buttons, eight slide switches and the processor's visible registers. It produces the processor's run enable and reset, and a 16-bit value plus four decimal-point lights for a hex display. The unit has four modes:

- free running, with a pause switch;
- halt on the output instruction or on a captured program-counter value;
- halt at every decode step, or on every clock;
- a memory mode in which the processor is held still.

A single continue button releases any halt.

The run enable is combinational from the processor's current state, so the processor stops in the very cycle it enters a halting state. A continue press grants one clock of run, which moves the processor out of that state before the halt is evaluated again.

Top module: `cpu_run_ctrl`

## Requirements
- R1: Each `btn_mode` pulse advances the mode to the next one in the order 0, 1, 2, 3, 0. Mode 0 is free run, mode 1 is the output/breakpoint halt, mode 2 is single step and mode 3 is memory.
- R2: `disp_dp` is one-hot with bit index equal to the mode: 4'b0001 in mode 0, 4'b0010 in mode 1, 4'b0100 in mode 2 and 4'b1000 in mode 3. Bit 0 is the rightmost dot.
- R3: In mode 0, when no grant is active, `cpu_run` equals the inverse of `sw[0]`.
- R4: `cpu_reset` follows `btn_rst` in modes 0 to 2 and is low in mode 3.
- R5: In mode 1, `cpu_run` is low whenever `cpu_state` equals the output-instruction code 12, unless a grant is active.
- R6: In mode 1, `cpu_run` drops in the cycle where `cpu_pc` equals the user address while the previous cycle's `cpu_pc` did not. It then stays low until a grant.
- R7: In mode 2, `cpu_run` is low whenever `cpu_state` equals the decode code 2, and on every cycle while `sw[0]` is high, unless a grant is active.
- R8: A `btn_go` pulse in modes 0 to 2 forces `cpu_run` high for exactly the next cycle. It also clears a pending breakpoint hold.
- R9: A `btn_cap` pulse in modes 0 to 2 loads `sw` into the user address used by R6. In mode 3 the pulse is ignored.
- R10: In mode 3, `cpu_run` is low on every cycle, and `btn_go` has no effect.
- R11: `disp_val` is chosen by the highest set switch among bits 7 to 3:
  - bit 7 gives {`cpu_pc`, `cpu_maddr`};
  - bit 6 gives `cpu_ir`;
  - bit 5 gives `cpu_mdata`;
  - bit 4 gives `cpu_acc`;
  - bit 3 gives `cpu_state`, zero-extended;
  - with none of them set, it gives `cpu_outreg`.
- R12: A synchronous active-low `rst_n` returns the unit to mode 0 and clears the user address, the grant, the breakpoint hold and the previous-PC history, which is set to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_go | input | 1 | Continue pulse |
| btn_rst | input | 1 | Processor reset button |
| btn_cap | input | 1 | Capture switches as user address |
| btn_mode | input | 1 | Advance operating mode |
| sw | input | 8 | Slide switches |
| cpu_state | input | 4 | Processor state code |
| cpu_pc | input | 8 | Processor program counter |
| cpu_maddr | input | 8 | Processor memory address |
| cpu_ir | input | 16 | Instruction register |
| cpu_mdata | input | 16 | Memory read data |
| cpu_acc | input | 16 | Accumulator |
| cpu_outreg | input | 16 | Output register |
| cpu_run | output | 1 | Run enable to processor |
| cpu_reset | output | 1 | Reset to processor |
| disp_val | output | 16 | Value for the hex display |
| disp_dp | output | 4 | Decimal points, one-hot mode |

## Verification
The run-enable path is tried with directed sequences, each in its own mode:

- a program counter walking into a captured address, which separates arrival from residence;
- a continue press while parked on a halting state, which shows that exactly one cycle is granted;
- a capture in memory mode, which must leave the breakpoint unchanged.

Random traffic then mixes state codes biased toward decode (2) and output (12) with program counters biased toward the user address, and with sparse button pulses. This exposes wrong priorities between grant, hold and level halts, and any mode-change corner.

The display selector is fed random switch words, so every priority level is hit alongside lower switches that are also set.

// File: rtl/cpu_run_ctrl_pkg.sv
// Package: shared mode encoding for the run-control unit.
// Assumes a two-bit mode field that wraps after the memory mode.
package cpu_run_ctrl_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_BRK  = 2'd1,
        MODE_STEP = 2'd2,
        MODE_MEM  = 2'd3
    } rc_mode_e;
endpackage

// File: rtl/rc_mode_ctrl.sv
// Module: cyclic mode register and user-address capture.
// Assumes button inputs are single-cycle debounced pulses.
module rc_mode_ctrl
    import cpu_run_ctrl_pkg::*;
#(
    parameter int SW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_pls,
    input  logic            cap_pls,
    input  logic [SW_W-1:0] sw,
    output rc_mode_e        mode,
    output logic [SW_W-1:0] uaddr
);

    // Advance the mode on each mode pulse, wrapping after memory mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_RUN;
        else if (mode_pls)
            mode <= rc_mode_e'(mode + 2'd1);
    end

    // Capture switches into the user address outside memory mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            uaddr <= '0;
        else if (cap_pls && mode != MODE_MEM)
            uaddr <= sw;
    end

    AST_MODE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MEM && mode_pls) |=> (mode == MODE_RUN)); // R1

    AST_UADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MEM) |=> $stable(uaddr)); // R9

endmodule

// File: rtl/rc_halt_logic.sv
// Module: computes the processor run enable from mode, state and PC.
// Assumes the processor state and PC are registered in the processor,
// so a combinational halt freezes them within the cycle they appear.
module rc_halt_logic
    import cpu_run_ctrl_pkg::*;
#(
    parameter int ST_W      = 4,
    parameter int ADDR_W    = 8,
    parameter int ST_DECODE = 2,
    parameter int ST_OUTPUT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rc_mode_e          mode,
    input  logic              go_pls,
    input  logic              pause_sw,
    input  logic [ST_W-1:0]   cpu_state,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic [ADDR_W-1:0] uaddr,
    output logic              run
);

    localparam logic [ST_W-1:0] DEC_CODE = ST_W'(ST_DECODE);
    localparam logic [ST_W-1:0] OUT_CODE = ST_W'(ST_OUTPUT);

    logic              grant_q;
    logic              bp_hold_q;
    logic [ADDR_W-1:0] pc_q;
    logic              bp_arrive;
    logic              lvl_stop;
    logic              stop;

    // Detect the PC arriving at the user address in breakpoint mode.
    always_comb begin
        bp_arrive = (mode == MODE_BRK) && (cpu_pc == uaddr) && (pc_q != uaddr);
    end

    // Level halt conditions per mode.
    always_comb begin
        unique case (mode)
            MODE_RUN:  lvl_stop = pause_sw;
            MODE_BRK:  lvl_stop = (cpu_state == OUT_CODE);
            MODE_STEP: lvl_stop = pause_sw || (cpu_state == DEC_CODE);
            default:   lvl_stop = 1'b1;
        endcase
        stop = lvl_stop || ((mode == MODE_BRK) && (bp_hold_q || bp_arrive));
    end

    // Run enable: never in memory mode, otherwise grant or no halt.
    always_comb begin
        run = (mode != MODE_MEM) && (grant_q || !stop);
    end

    // One-cycle grant, sticky breakpoint hold and PC history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q   <= 1'b0;
            bp_hold_q <= 1'b0;
            pc_q      <= '0;
        end else begin
            grant_q   <= go_pls && (mode != MODE_MEM);
            bp_hold_q <= (mode == MODE_BRK) && (bp_hold_q || bp_arrive) && !go_pls;
            pc_q      <= cpu_pc;
        end
    end

    AST_MEM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MEM) |-> !run); // R10

    AST_STEP_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STEP && cpu_state == DEC_CODE && !grant_q) |-> !run); // R7

    AST_OUT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BRK && cpu_state == OUT_CODE && !grant_q) |-> !run); // R5

    AST_GRANT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pls && mode != MODE_MEM) |=> (run || mode == MODE_MEM)); // R8

    AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BRK && bp_hold_q && !grant_q) |-> !run); // R6

endmodule

// File: rtl/rc_disp_sel.sv
// Module: priority selector for the hex display value.
// Assumes DATA_W >= 2*ADDR_W and at least eight switches.
module rc_disp_sel #(
    parameter int SW_W   = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int ST_W   = 4
) (
    input  logic [SW_W-1:0]   sw,
    input  logic [ST_W-1:0]   cpu_state,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic [ADDR_W-1:0] cpu_maddr,
    input  logic [DATA_W-1:0] cpu_ir,
    input  logic [DATA_W-1:0] cpu_mdata,
    input  logic [DATA_W-1:0] cpu_acc,
    input  logic [DATA_W-1:0] cpu_outreg,
    output logic [DATA_W-1:0] disp_val
);

    localparam int SEL_ADR = 7;
    localparam int SEL_IR  = 6;
    localparam int SEL_MD  = 5;
    localparam int SEL_AC  = 4;
    localparam int SEL_ST  = 3;
    localparam int PAD_W   = DATA_W - 2 * ADDR_W;

    logic [DATA_W-1:0] addr_pair;

    // Pack PC and memory address, padding only if the display is wider.
    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_pair = {{PAD_W{1'b0}}, cpu_pc, cpu_maddr};
        end else begin : g_nopad
            assign addr_pair = {cpu_pc, cpu_maddr};
        end
    endgenerate

    // Highest set switch wins.
    always_comb begin
        if (sw[SEL_ADR])     disp_val = addr_pair;
        else if (sw[SEL_IR]) disp_val = cpu_ir;
        else if (sw[SEL_MD]) disp_val = cpu_mdata;
        else if (sw[SEL_AC]) disp_val = cpu_acc;
        else if (sw[SEL_ST]) disp_val = DATA_W'(cpu_state);
        else                 disp_val = cpu_outreg;
    end

endmodule

// File: rtl/cpu_run_ctrl.sv
// Module: top of the run-control and breakpoint unit.
// Assumes debounced single-cycle button pulses and a processor whose
// registers only advance while cpu_run is high.
module cpu_run_ctrl
    import cpu_run_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int ST_W      = 4,
    parameter int ST_DECODE = 2,
    parameter int ST_OUTPUT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_go,
    input  logic              btn_rst,
    input  logic              btn_cap,
    input  logic              btn_mode,
    input  logic [ADDR_W-1:0] sw,
    input  logic [ST_W-1:0]   cpu_state,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic [ADDR_W-1:0] cpu_maddr,
    input  logic [DATA_W-1:0] cpu_ir,
    input  logic [DATA_W-1:0] cpu_mdata,
    input  logic [DATA_W-1:0] cpu_acc,
    input  logic [DATA_W-1:0] cpu_outreg,
    output logic              cpu_run,
    output logic              cpu_reset,
    output logic [DATA_W-1:0] disp_val,
    output logic [3:0]        disp_dp
);

    rc_mode_e          mode;
    logic [ADDR_W-1:0] uaddr;

    rc_mode_ctrl #(.SW_W(ADDR_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_pls (btn_mode),
        .cap_pls  (btn_cap),
        .sw       (sw),
        .mode     (mode),
        .uaddr    (uaddr)
    );

    rc_halt_logic #(
        .ST_W      (ST_W),
        .ADDR_W    (ADDR_W),
        .ST_DECODE (ST_DECODE),
        .ST_OUTPUT (ST_OUTPUT)
    ) u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .go_pls    (btn_go),
        .pause_sw  (sw[0]),
        .cpu_state (cpu_state),
        .cpu_pc    (cpu_pc),
        .uaddr     (uaddr),
        .run       (cpu_run)
    );

    rc_disp_sel #(
        .SW_W   (ADDR_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ST_W   (ST_W)
    ) u_disp (
        .sw         (sw),
        .cpu_state  (cpu_state),
        .cpu_pc     (cpu_pc),
        .cpu_maddr  (cpu_maddr),
        .cpu_ir     (cpu_ir),
        .cpu_mdata  (cpu_mdata),
        .cpu_acc    (cpu_acc),
        .cpu_outreg (cpu_outreg),
        .disp_val   (disp_val)
    );

    // Processor reset passes through except in memory mode.
    always_comb begin
        cpu_reset = btn_rst && (mode != MODE_MEM);
    end

    // One-hot decimal points indexed by mode.
    always_comb begin
        disp_dp = 4'b0001 << mode;
    end

    AST_RST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MEM) |-> !cpu_reset); // R4

    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && !sw[0]) |-> cpu_run); // R3

endmodule

// File: tb/cpu_run_ctrl_test.sv
module cpu_run_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        btn_go, btn_rst, btn_cap, btn_mode;
    logic [7:0]  sw;
    logic [3:0]  cpu_state;
    logic [7:0]  cpu_pc, cpu_maddr;
    logic [15:0] cpu_ir, cpu_mdata, cpu_acc, cpu_outreg;
    logic        cpu_run, cpu_reset;
    logic [15:0] disp_val;
    logic [3:0]  disp_dp;

    int n_chk = 0;
    int n_err = 0;

    // Bench model of the requirement-level state.
    logic [1:0] m_mode;
    logic [7:0] m_ua, m_pcq;
    logic       m_grant, m_hold;

    cpu_run_ctrl uut (
        .clk(clk), .rst_n(rst_n), .btn_go(btn_go), .btn_rst(btn_rst),
        .btn_cap(btn_cap), .btn_mode(btn_mode), .sw(sw),
        .cpu_state(cpu_state), .cpu_pc(cpu_pc), .cpu_maddr(cpu_maddr),
        .cpu_ir(cpu_ir), .cpu_mdata(cpu_mdata), .cpu_acc(cpu_acc),
        .cpu_outreg(cpu_outreg), .cpu_run(cpu_run), .cpu_reset(cpu_reset),
        .disp_val(disp_val), .disp_dp(disp_dp)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R11 display priority.
    function automatic logic [15:0] exp_disp();
        if (sw[7])      return {cpu_pc, cpu_maddr};
        else if (sw[6]) return cpu_ir;
        else if (sw[5]) return cpu_mdata;
        else if (sw[4]) return cpu_acc;
        else if (sw[3]) return {12'd0, cpu_state};
        else            return cpu_outreg;
    endfunction

    function automatic logic bp_arr();
        return (m_mode == 2'd1) && (cpu_pc == m_ua) && (m_pcq != m_ua);
    endfunction

    function automatic logic exp_run();
        logic lvl;
        case (m_mode)
            2'd0: lvl = sw[0];
            2'd1: lvl = (cpu_state == 4'd12);
            2'd2: lvl = sw[0] || (cpu_state == 4'd2);
            default: lvl = 1'b1;
        endcase
        lvl = lvl || ((m_mode == 2'd1) && (m_hold || bp_arr()));
        return (m_mode != 2'd3) && (m_grant || !lvl);
    endfunction

    task automatic set_in(logic go, logic rs, logic cap, logic md,
                          logic [7:0] s, logic [3:0] st, logic [7:0] pc);
        btn_go = go; btn_rst = rs; btn_cap = cap; btn_mode = md;
        sw = s; cpu_state = st; cpu_pc = pc;
        cpu_maddr = 8'($urandom); cpu_ir = 16'($urandom);
        cpu_mdata = 16'($urandom); cpu_acc = 16'($urandom);
        cpu_outreg = 16'($urandom);
    endtask

    // Check outputs mid-cycle, then clock and update the model.
    task automatic tick();
        string tag;
        #1;
        if (rst_n) begin
            if (m_mode == 2'd3)      tag = "R10";
            else if (m_grant)        tag = "R8";
            else if (m_mode == 2'd0) tag = "R3";
            else if (m_mode == 2'd1) tag = (m_hold || bp_arr()) ? "R6" : "R5";
            else                     tag = "R7";
            chk(tag, 32'(cpu_run), 32'(exp_run()));
            chk("R4", 32'(cpu_reset), 32'(btn_rst && m_mode != 2'd3));
            chk("R11", 32'(disp_val), 32'(exp_disp()));
            chk("R1 R2", 32'(disp_dp), 32'(4'b0001 << m_mode));
        end
        @(posedge clk);
        if (!rst_n) begin
            m_mode = 0; m_ua = 0; m_pcq = 0; m_grant = 0; m_hold = 0;
        end else begin
            m_hold  = (m_mode == 2'd1) && (m_hold || bp_arr()) && !btn_go;
            m_grant = btn_go && (m_mode != 2'd3);
            if (btn_cap && m_mode != 2'd3) m_ua = sw;
            m_pcq = cpu_pc;
            m_mode = m_mode + 2'd1 * 2'(btn_mode);
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        set_in(0, 0, 0, 0, 8'h00, 4'd1, 8'h00);
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;

        // R12: reset state is mode 0, free running, user address 0.
        set_in(0, 0, 0, 0, 8'h00, 4'd1, 8'h00);
        #1;
        chk("R12", 32'(disp_dp), 32'h1);
        chk("R12", 32'(cpu_run), 32'h1);
        tick();
        // R12: enter mode 1, walk PC 5 -> 0; cleared user address hits.
        set_in(0, 0, 0, 1, 8'h00, 4'd1, 8'h05); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd1, 8'h05); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd1, 8'h00); #1;
        chk("R12", 32'(cpu_run), 32'h0);
        tick();

        // R9/R6: capture 0x18, walk PC 16, 17, 18.
        set_in(1, 0, 1, 0, 8'h18, 4'd1, 8'h16); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd3, 8'h17); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd2, 8'h18); #1;
        chk("R9", 32'(cpu_run), 32'h0);
        tick();
        for (int i = 0; i < 3; i++) begin
            set_in(0, 0, 0, 0, 8'h00, 4'd2, 8'h18); #1;
            chk("R6", 32'(cpu_run), 32'h0);
            tick();
        end
        set_in(1, 0, 0, 0, 8'h00, 4'd2, 8'h18); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd2, 8'h18); #1;
        chk("R8", 32'(cpu_run), 32'h1);
        tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd5, 8'h18); #1;
        chk("R6", 32'(cpu_run), 32'h1);
        tick();

        // R5: output state halts in mode 1.
        set_in(0, 0, 0, 0, 8'h00, 4'd12, 8'h19); #1;
        chk("R5", 32'(cpu_run), 32'h0);
        tick();

        // R7: mode 2, decode halts; pause switch halts any state.
        set_in(0, 0, 0, 1, 8'h00, 4'd12, 8'h19); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd2, 8'h19); #1;
        chk("R7", 32'(cpu_run), 32'h0);
        tick();
        set_in(0, 0, 0, 0, 8'h01, 4'd9, 8'h19); #1;
        chk("R7", 32'(cpu_run), 32'h0);
        tick();

        // R10/R4/R9: memory mode ignores go, reset and capture.
        set_in(0, 0, 0, 1, 8'h00, 4'd1, 8'h19); tick();
        set_in(1, 1, 1, 0, 8'h40, 4'd1, 8'h19); #1;
        chk("R4", 32'(cpu_reset), 32'h0);
        tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd1, 8'h19); #1;
        chk("R10", 32'(cpu_run), 32'h0);
        tick();
        // R1: wrap back to mode 0.
        set_in(0, 0, 0, 1, 8'h00, 4'd1, 8'h19); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd1, 8'h19); #1;
        chk("R1", 32'(disp_dp), 32'h1);
        tick();
        // R9: mode 1, PC walks to 0x40; must not halt (capture was ignored).
        set_in(0, 0, 0, 1, 8'h00, 4'd1, 8'h3f); tick();
        set_in(0, 0, 0, 0, 8'h00, 4'd1, 8'h40); #1;
        chk("R9", 32'(cpu_run), 32'h1);
        tick();

        // Random traffic checked against the bench model.
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] st;
            logic [7:0] pc;
            case ($urandom % 4)
                0: st = 4'd1;
                1: st = 4'd2;
                2: st = 4'd12;
                default: st = 4'($urandom % 13);
            endcase
            pc = ($urandom % 4 == 0) ? m_ua : 8'($urandom);
            set_in(($urandom % 8) == 0, ($urandom % 20) == 0,
                   ($urandom % 30) == 0, ($urandom % 40) == 0,
                   8'($urandom), st, pc);
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule